// File: doc/BRIEF.md
# Address Translation Window Unit

This block sits inside a bus bridge. It holds a small set of address translation windows: four for traffic from the CPU to the bus, and three for traffic from the bus to the CPU. Software programs the windows through a 32-bit register port that covers a 4 KB region. A window is described by a base page, a translation page and an attribute word. The attribute word carries an enable bit and a power-of-two size code.

Two lookup ports run in parallel. Each port takes an address and returns a hit flag and a translated address. The outbound port searches the outbound set and the inbound port searches the inbound set. A hit means the address lies inside an enabled window. The translated address is the window's translation address plus the distance from the window base. When several windows match, the lowest-numbered one is used. A spare 32-bit register only stores what is written to it. Lookups are combinational on the current register contents, so a register write is seen by lookups from the next clock cycle.

Top module: `xlate_window_unit`

## Requirements
- R1: After reset, every register reads zero and both lookup ports report no hit with a zero address.
- R2: Outbound window k (k = 0..3) occupies offsets 0xC20 + 32·k. Its fields sit at byte offsets within the group as follows: translation page +0x0, extended translation +0x4, base page +0x8, attributes +0x10. Each field is written and read back as a full 32-bit word.
- R3: Inbound window k (k = 0..2) occupies offsets 0xDA0 + 32·k. Its fields sit at byte offsets within the group as follows: translation page +0x0, base page +0x8, extended base +0xC, attributes +0x10. Each field is read back as written.
- R4: The spare register is reached by any offset from 0xE20 to 0xE3F. It stores and returns the last written word and has no other effect.
- R5: A read of any offset not named in R2–R4 returns zero, and a write to such an offset changes no register and no lookup result.
- R6: A window takes part in lookups only while attribute bit 31 is set. Its size in bytes is 2 << (attribute bits 5:0); a size of 2^32 or more covers the whole 32-bit space.
- R7: The base and translation fields hold page numbers. The byte address is the field shifted left by 12, truncated to the lookup address width.
- R8: An outbound lookup of address A hits window k when base ≤ A < base + size. The result is then translation + (A − base), modulo 2^32.
- R9: The inbound lookup applies the R8 rule to the inbound window set, independently of the outbound port.
- R10: When more than one enabled window of a set matches, the window with the lowest number supplies the result.
- R11: When no window matches, the hit flag is 0 and the translated address is 0.
- R12: During the cycle in which a register write is presented, lookups still reflect the old contents. From the next cycle on, they reflect the new contents.
- R13: The extended translation and extended base fields are stored only; writing them never changes a lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset within the 4 KB region |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ob_addr | input | ADDR_W | Outbound lookup address (CPU side) |
| ob_hit | output | 1 | Outbound lookup matched an enabled window |
| ob_xaddr | output | ADDR_W | Translated bus-side address, zero on a miss |
| ib_addr | input | ADDR_W | Inbound lookup address (bus side) |
| ib_hit | output | 1 | Inbound lookup matched an enabled window |
| ib_xaddr | output | ADDR_W | Translated CPU-side address, zero on a miss |

## Verification
Register writes and lookups can fall in the same cycle. A write to a window's base, translation or attribute field can change the result of a lookup that is being presented at that moment. The bench holds a lookup address steady while it presents a write. It checks both lookup ports before the clock edge against the unchanged model, and again after the edge against the updated model. Random writes spread over the whole offset range mix window edits, writes to undecoded offsets and lookups near window edges, so every write is judged at both instants.

// File: rtl/xwu_pkg.sv
package xwu_pkg;

   // Page granularity of base and translation fields
   localparam int PAGE_SHIFT = 12;
   localparam int SIZE_CODE_W = 6;
   localparam int ENABLE_BIT = 31;

   // Field offsets inside a 32-byte window group
   localparam logic [4:0] FLD_TRANS = 5'h00;
   localparam logic [4:0] FLD_OB_EXT = 5'h04;
   localparam logic [4:0] FLD_BASE = 5'h08;
   localparam logic [4:0] FLD_IB_EXT = 5'h0C;
   localparam logic [4:0] FLD_ATTR = 5'h10;

   // Address-bit patterns of the register groups
   localparam logic [3:0] OB_PAGE_NIB = 4'hC;
   localparam logic [3:0] IB_PAGE_NIB = 4'hD;
   localparam logic [6:0] SPARE_GROUP = 7'h71;   // offset 0xE20 >> 5

   typedef struct packed {
      logic [31:0] trans;
      logic [31:0] ext;
      logic [31:0] base;
      logic [31:0] attr;
   } win_regs_t;

endpackage

// File: rtl/xwu_win_regs.sv
module xwu_win_regs
   import xwu_pkg::*;
#(
   parameter logic [4:0] EXT_FLD = FLD_OB_EXT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [4:0]       fld,
   input  logic [31:0]      wdata,
   output win_regs_t        q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         if (fld == FLD_TRANS) q.trans <= wdata;
         if (fld == EXT_FLD)   q.ext   <= wdata;
         if (fld == FLD_BASE)  q.base  <= wdata;
         if (fld == FLD_ATTR)  q.attr  <= wdata;
      end
   end

endmodule

// File: rtl/xwu_win_match.sv
module xwu_win_match
   import xwu_pkg::*;
#(
   parameter int ADDR_W = 32,
   localparam int PG_W = ADDR_W - PAGE_SHIFT
) (
   input  logic                   en,
   input  logic [SIZE_CODE_W-1:0] code,
   input  logic [PG_W-1:0]        base_pg,
   input  logic [PG_W-1:0]        trans_pg,
   input  logic [ADDR_W-1:0]      addr,
   output logic                   hit,
   output logic [ADDR_W-1:0]      xaddr
);

   logic [ADDR_W-1:0] base_b;
   logic [ADDR_W-1:0] trans_b;
   logic [ADDR_W:0]   diff;
   logic [ADDR_W-1:0] off;
   logic [SIZE_CODE_W:0] keep_bits;
   logic              in_size;

   assign base_b  = {base_pg, {PAGE_SHIFT{1'b0}}};
   assign trans_b = {trans_pg, {PAGE_SHIFT{1'b0}}};
   assign diff    = {1'b0, addr} - {1'b0, base_b};
   assign off     = diff[ADDR_W-1:0];
   assign keep_bits = {1'b0, code} + 7'd1;

   always_comb begin
      if (int'(code) >= ADDR_W - 1) in_size = 1'b1;
      else                          in_size = ((off >> keep_bits) == '0);
   end

   assign hit   = en && !diff[ADDR_W] && in_size;
   assign xaddr = trans_b + off;

endmodule

// File: rtl/xwu_lookup.sv
module xwu_lookup
   import xwu_pkg::*;
#(
   parameter int N = 4,
   parameter int ADDR_W = 32,
   localparam int PG_W = ADDR_W - PAGE_SHIFT
) (
   input  logic [N-1:0]                  en,
   input  logic [N-1:0][SIZE_CODE_W-1:0] code,
   input  logic [N-1:0][PG_W-1:0]        base_pg,
   input  logic [N-1:0][PG_W-1:0]        trans_pg,
   input  logic [ADDR_W-1:0]             addr,
   output logic                          hit,
   output logic [ADDR_W-1:0]             xaddr
);

   logic [N-1:0]             win_hit;
   logic [N-1:0][ADDR_W-1:0] win_x;

   for (genvar w = 0; w < N; w++) begin : g_win
      xwu_win_match #(.ADDR_W(ADDR_W)) u_match (
         .en      (en[w]),
         .code    (code[w]),
         .base_pg (base_pg[w]),
         .trans_pg(trans_pg[w]),
         .addr    (addr),
         .hit     (win_hit[w]),
         .xaddr   (win_x[w])
      );
   end

   // Lowest-numbered matching window wins: scan from the top down
   always_comb begin
      hit   = 1'b0;
      xaddr = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (win_hit[i]) begin
            hit   = 1'b1;
            xaddr = win_x[i];
         end
      end
   end

endmodule

// File: rtl/xlate_window_unit.sv
module xlate_window_unit
   import xwu_pkg::*;
#(
   parameter int N_OUT = 4,
   parameter int N_IN = 3,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] ob_addr,
   output logic              ob_hit,
   output logic [ADDR_W-1:0] ob_xaddr,
   input  logic [ADDR_W-1:0] ib_addr,
   output logic              ib_hit,
   output logic [ADDR_W-1:0] ib_xaddr
);

   localparam int PG_W = ADDR_W - PAGE_SHIFT;
   localparam int OB_IW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
   localparam int IB_IW = (N_IN > 1) ? $clog2(N_IN) : 1;

   initial begin : p_param_check
      assert (N_OUT >= 1 && N_OUT <= 4) else $fatal(1, "N_OUT must be 1..4");
      assert (N_IN >= 1 && N_IN <= 3) else $fatal(1, "N_IN must be 1..3");
      assert (ADDR_W > PAGE_SHIFT && ADDR_W <= 32 + PAGE_SHIFT)
         else $fatal(1, "ADDR_W out of range");
   end

   // ---------------- decode ----------------
   logic [4:0]       fld;
   logic [2:0]       ob_slot;
   logic [1:0]       ib_slot;
   logic [OB_IW-1:0] ob_idx;
   logic [IB_IW-1:0] ib_idx;
   logic             ob_grp, ib_grp, spare_sel;

   assign fld     = reg_addr[4:0];
   assign ob_slot = reg_addr[7:5];
   assign ib_slot = reg_addr[6:5];
   assign ob_idx  = OB_IW'(ob_slot - 3'd1);
   assign ib_idx  = IB_IW'(ib_slot - 2'd1);

   assign ob_grp = (reg_addr[11:8] == OB_PAGE_NIB) && (ob_slot != 3'd0)
                   && (int'(ob_slot) <= N_OUT);
   assign ib_grp = (reg_addr[11:8] == IB_PAGE_NIB) && reg_addr[7]
                   && (ib_slot != 2'd0) && (int'(ib_slot) <= N_IN);
   assign spare_sel = (reg_addr[11:5] == SPARE_GROUP);

   // ---------------- storage ----------------
   win_regs_t   ob_q [N_OUT];
   win_regs_t   ib_q [N_IN];
   logic [31:0] timer_q;

   logic [N_OUT-1:0]                  ob_en;
   logic [N_OUT-1:0][SIZE_CODE_W-1:0] ob_code;
   logic [N_OUT-1:0][PG_W-1:0]        ob_base_pg, ob_trans_pg;
   logic [N_IN-1:0]                   ib_en;
   logic [N_IN-1:0][SIZE_CODE_W-1:0]  ib_code;
   logic [N_IN-1:0][PG_W-1:0]         ib_base_pg, ib_trans_pg;

   for (genvar k = 0; k < N_OUT; k++) begin : g_ob
      xwu_win_regs #(.EXT_FLD(FLD_OB_EXT)) u_regs (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (reg_wr && ob_grp && (int'(ob_idx) == k)),
         .fld  (fld),
         .wdata(reg_wdata),
         .q    (ob_q[k])
      );
      assign ob_en[k]       = ob_q[k].attr[ENABLE_BIT];
      assign ob_code[k]     = ob_q[k].attr[SIZE_CODE_W-1:0];
      assign ob_base_pg[k]  = ob_q[k].base[PG_W-1:0];
      assign ob_trans_pg[k] = ob_q[k].trans[PG_W-1:0];
   end

   for (genvar k = 0; k < N_IN; k++) begin : g_ib
      xwu_win_regs #(.EXT_FLD(FLD_IB_EXT)) u_regs (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (reg_wr && ib_grp && (int'(ib_idx) == k)),
         .fld  (fld),
         .wdata(reg_wdata),
         .q    (ib_q[k])
      );
      assign ib_en[k]       = ib_q[k].attr[ENABLE_BIT];
      assign ib_code[k]     = ib_q[k].attr[SIZE_CODE_W-1:0];
      assign ib_base_pg[k]  = ib_q[k].base[PG_W-1:0];
      assign ib_trans_pg[k] = ib_q[k].trans[PG_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   timer_q <= '0;
      else if (reg_wr && spare_sel) timer_q <= reg_wdata;
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (ob_grp) begin
         unique case (fld)
            FLD_TRANS:  reg_rdata = ob_q[ob_idx].trans;
            FLD_OB_EXT: reg_rdata = ob_q[ob_idx].ext;
            FLD_BASE:   reg_rdata = ob_q[ob_idx].base;
            FLD_ATTR:   reg_rdata = ob_q[ob_idx].attr;
            default:    reg_rdata = '0;
         endcase
      end else if (ib_grp) begin
         unique case (fld)
            FLD_TRANS:  reg_rdata = ib_q[ib_idx].trans;
            FLD_BASE:   reg_rdata = ib_q[ib_idx].base;
            FLD_IB_EXT: reg_rdata = ib_q[ib_idx].ext;
            FLD_ATTR:   reg_rdata = ib_q[ib_idx].attr;
            default:    reg_rdata = '0;
         endcase
      end else if (spare_sel) begin
         reg_rdata = timer_q;
      end
   end

   // ---------------- lookups ----------------
   xwu_lookup #(.N(N_OUT), .ADDR_W(ADDR_W)) u_ob_lookup (
      .en      (ob_en),
      .code    (ob_code),
      .base_pg (ob_base_pg),
      .trans_pg(ob_trans_pg),
      .addr    (ob_addr),
      .hit     (ob_hit),
      .xaddr   (ob_xaddr)
   );

   xwu_lookup #(.N(N_IN), .ADDR_W(ADDR_W)) u_ib_lookup (
      .en      (ib_en),
      .code    (ib_code),
      .base_pg (ib_base_pg),
      .trans_pg(ib_trans_pg),
      .addr    (ib_addr),
      .hit     (ib_hit),
      .xaddr   (ib_xaddr)
   );

endmodule

// File: rtl/xwu_checker.sv
module xwu_checker #(
   parameter int N_OUT = 4,
   parameter int N_IN = 3,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [11:0]       reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic [ADDR_W-1:0] ob_addr,
   input logic              ob_hit,
   input logic [ADDR_W-1:0] ob_xaddr,
   input logic [ADDR_W-1:0] ib_addr,
   input logic              ib_hit,
   input logic [ADDR_W-1:0] ib_xaddr,
   input logic [N_OUT-1:0]  ob_en,
   input logic [N_IN-1:0]   ib_en,
   input logic [31:0]       timer_q
);

   a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (ob_en == '0 && ib_en == '0 && timer_q == 32'h0));

   a_r4_spare_store: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[11:5] == 7'h71) |=> timer_q == $past(reg_wdata));

   a_r4_spare_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr[11:5] == 7'h71) |=> $stable(timer_q));

   a_r5_low_region_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr < 12'hC00) |-> reg_rdata == 32'h0);

   a_r6_ob_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_en == '0) |-> !ob_hit);

   a_r6_ib_all_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_en == '0) |-> !ib_hit);

   a_r11_ob_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ob_hit |-> ob_xaddr == '0);

   a_r11_ib_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ib_hit |-> ib_xaddr == '0);

   a_r13_ob_ext_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[11:8] == 4'hC && reg_addr[4:0] == 5'h04)
      |=> (!$stable(ob_addr) || ($stable(ob_hit) && $stable(ob_xaddr))));

   a_r13_ib_ext_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[11:8] == 4'hD && reg_addr[4:0] == 5'h0C)
      |=> (!$stable(ib_addr) || ($stable(ib_hit) && $stable(ib_xaddr))));

endmodule

bind xlate_window_unit xwu_checker #(
   .N_OUT (N_OUT),
   .N_IN  (N_IN),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .ob_addr  (ob_addr),
   .ob_hit   (ob_hit),
   .ob_xaddr (ob_xaddr),
   .ib_addr  (ib_addr),
   .ib_hit   (ib_hit),
   .ib_xaddr (ib_xaddr),
   .ob_en    (ob_en),
   .ib_en    (ib_en),
   .timer_q  (timer_q)
);

// File: tb/sim_xlate_window_unit.sv
`timescale 1ns/1ps
module sim_xlate_window_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] ob_addr = '0;
   logic        ob_hit;
   logic [31:0] ob_xaddr;
   logic [31:0] ib_addr = '0;
   logic        ib_hit;
   logic [31:0] ib_xaddr;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   xlate_window_unit u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ob_addr(ob_addr), .ob_hit(ob_hit), .ob_xaddr(ob_xaddr),
      .ib_addr(ib_addr), .ib_hit(ib_hit), .ib_xaddr(ib_xaddr)
   );

   // model: field index 0 trans, 1 extended, 2 base, 3 attributes
   logic [31:0] m_ob [4][4];
   logic [31:0] m_ib [3][4];
   logic [31:0] m_spare;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // kind: 0 none, 1 outbound, 2 inbound, 3 spare (R2, R3, R4, R5)
   function automatic int decode(logic [11:0] a, output int idx, output int f);
      logic [11:0] g;
      g = a & 12'hFE0;
      idx = 0;
      f = 0;
      if (g == 12'hC20 || g == 12'hC40 || g == 12'hC60 || g == 12'hC80) begin
         idx = int'((a >> 5) & 12'h7) - 1;
         case (a[4:0])
            5'h00: f = 0;
            5'h04: f = 1;
            5'h08: f = 2;
            5'h10: f = 3;
            default: return 0;
         endcase
         return 1;
      end
      if (g == 12'hDA0 || g == 12'hDC0 || g == 12'hDE0) begin
         idx = int'((a >> 5) & 12'h3) - 1;
         case (a[4:0])
            5'h00: f = 0;
            5'h0C: f = 1;
            5'h08: f = 2;
            5'h10: f = 3;
            default: return 0;
         endcase
         return 2;
      end
      if (g == 12'hE20) return 3;
      return 0;
   endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a);
      int idx, f, kind;
      kind = decode(a, idx, f);
      case (kind)
         1: return m_ob[idx][f];
         2: return m_ib[idx][f];
         3: return m_spare;
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_write(logic [11:0] a, logic [31:0] d);
      int idx, f, kind;
      kind = decode(a, idx, f);
      case (kind)
         1: m_ob[idx][f] = d;
         2: m_ib[idx][f] = d;
         3: m_spare = d;
         default: ;
      endcase
   endtask

   // R6, R7, R8, R9, R10, R11
   function automatic logic [32:0] exp_look(bit inb, logic [31:0] a);
      int n;
      n = inb ? 3 : 4;
      for (int i = 0; i < n; i++) begin
         logic [31:0] tr, bs, at;
         logic [63:0] base, off;
         tr = inb ? m_ib[i][0] : m_ob[i][0];
         bs = inb ? m_ib[i][2] : m_ob[i][2];
         at = inb ? m_ib[i][3] : m_ob[i][3];
         if (at[31]) begin
            base = {32'h0, bs[19:0], 12'h000};
            if ({32'h0, a} >= base) begin
               off = {32'h0, a} - base;
               if (at[5:0] >= 6'd31 || off < (64'd2 << at[5:0]))
                  return {1'b1, {tr[19:0], 12'h000} + off[31:0]};
            end
         end
      end
      return 33'h0;
   endfunction

   task automatic check_look(string tag);
      logic [32:0] e;
      e = exp_look(1'b0, ob_addr);
      check({tag, " ob"}, {31'h0, ob_hit, ob_xaddr}, {31'h0, e});
      e = exp_look(1'b1, ib_addr);
      check({tag, " ib"}, {31'h0, ib_hit, ib_xaddr}, {31'h0, e});
   endtask

   // write with same-cycle (old contents) and next-cycle (new contents) lookup checks
   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      #1;
      check_look("R12 same-cycle lookup");
      @(posedge clk);
      model_write(a, d);
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      check_look("R12 next-cycle lookup");
   endtask

   task automatic rd(logic [11:0] a, string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, {32'h0, reg_rdata}, {32'h0, exp_read(a)});
   endtask

   task automatic look(logic [31:0] oa, logic [31:0] ia, string tag);
      @(negedge clk);
      ob_addr = oa;
      ib_addr = ia;
      #1;
      check_look(tag);
   endtask

   function automatic logic [31:0] rand_attr();
      logic [5:0] c;
      c = ($urandom % 8 == 0) ? 6'd63 : 6'(8 + $urandom % 12);
      return {($urandom % 4 != 0), 25'($urandom), c};
   endfunction

   function automatic logic [31:0] near_addr(bit inb, int i);
      logic [31:0] bs, at, lim;
      bs = inb ? m_ib[i][2] : m_ob[i][2];
      at = inb ? m_ib[i][3] : m_ob[i][3];
      lim = (at[5:0] >= 6'd20) ? 32'h0020_0000 : (32'd4 << at[5:0]);
      return {bs[19:0], 12'h000} + ($urandom % lim);
   endfunction

   bit done = 1'b0;

   initial begin
      #400000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [32:0] keep;
      void'($urandom(32'h1D5EED));
      for (int i = 0; i < 4; i++) for (int f = 0; f < 4; f++) m_ob[i][f] = '0;
      for (int i = 0; i < 3; i++) for (int f = 0; f < 4; f++) m_ib[i][f] = '0;
      m_spare = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(12'hC20, "R1 reset ob trans");
      rd(12'hC90, "R1 reset ob attr");
      rd(12'hDE8, "R1 reset ib base");
      rd(12'hE20, "R1 reset spare");
      look(32'h0000_0000, 32'h1234_5678, "R1 reset lookup");

      // R2 / R3: field placement and read-back
      wr(12'hC44, 32'hA5A5_0001);
      rd(12'hC44, "R2 ob1 extended");
      wr(12'hC60, 32'h0000_0777);
      rd(12'hC60, "R2 ob2 trans");
      wr(12'hDCC, 32'h5A5A_0002);
      rd(12'hDCC, "R3 ib1 extended");
      wr(12'hDA8, 32'h0000_0abc);
      rd(12'hDA8, "R3 ib0 base");

      // R4: spare register and its aliases
      wr(12'hE20, 32'hDEAD_BEEF);
      rd(12'hE20, "R4 spare");
      rd(12'hE3C, "R4 spare alias");
      wr(12'hE37, 32'h0BAD_F00D);
      rd(12'hE20, "R4 spare via alias write");

      // R6, R7, R8: outbound window 0, base page 0x10, trans page 0x80, 4 KB
      wr(12'hC28, 32'h0000_0010);
      wr(12'hC20, 32'h0000_0080);
      wr(12'hC30, 32'h0000_000B);
      look(32'h0001_0010, 32'h0, "R6 disabled window misses");
      wr(12'hC30, 32'h8000_000B);
      look(32'h0001_0010, 32'h0, "R8 hit inside window");
      look(32'h0001_0FFF, 32'h0, "R6 last byte of window");
      look(32'h0001_1000, 32'h0, "R6 first byte past window");
      look(32'h0000_FFFF, 32'h0, "R11 below base misses");

      // R10: window 1 overlaps window 0 with a 64 KB window
      wr(12'hC48, 32'h0000_0010);
      wr(12'hC40, 32'h0000_0200);
      wr(12'hC50, 32'h8000_000F);
      look(32'h0001_0010, 32'h0, "R10 lowest index wins");
      look(32'h0001_1000, 32'h0, "R10 second window only");

      // R9: inbound window 2
      wr(12'hDE8, 32'h0000_0040);
      wr(12'hDE0, 32'h0000_0005);
      wr(12'hDF0, 32'h8000_000C);
      look(32'h0004_0100, 32'h0004_0100, "R9 inbound hit");
      look(32'h0001_0010, 32'h0004_2000, "R9 inbound edge");

      // R5: undecoded offsets
      wr(12'hC0C, 32'hFFFF_FFFF);
      wr(12'hC2C, 32'hFFFF_FFFF);
      wr(12'hDA4, 32'hFFFF_FFFF);
      wr(12'hD80, 32'hFFFF_FFFF);
      wr(12'h100, 32'hFFFF_FFFF);
      rd(12'hC2C, "R5 undecoded ob field");
      rd(12'hDA4, "R5 undecoded ib field");
      rd(12'h100, "R5 low region");
      rd(12'hC20, "R5 neighbour unchanged");
      look(32'h0001_0010, 32'h0004_0100, "R5 lookup unchanged");

      // R12: enable a window while its lookup is presented
      look(32'h0003_0040, 32'h0, "R12 setup");
      wr(12'hC88, 32'h0000_0030);
      wr(12'hC80, 32'h0000_0007);
      wr(12'hC90, 32'h8000_000A);

      // R13: extended fields leave lookups alone
      look(32'h0001_0010, 32'h0004_0100, "R13 setup");
      keep = {ob_hit, ob_xaddr};
      wr(12'hC24, 32'hFFFF_FFFF);
      wr(12'hDEC, 32'hFFFF_FFFF);
      check("R13 ob result after extended write", {31'h0, ob_hit, ob_xaddr}, {31'h0, keep});

      // random phase
      for (int it = 0; it < 2500; it++) begin
         int op, w, f;
         logic [11:0] a;
         op = $urandom % 5;
         if (op == 0) begin
            w = $urandom % 4;
            f = $urandom % 4;
            a = 12'hC20 + 12'(w * 32) + ((f == 3) ? 12'h10 : 12'(f * 4));
            wr(a, (f == 3) ? rand_attr() : $urandom);
         end else if (op == 1) begin
            w = $urandom % 3;
            f = $urandom % 4;
            case (f)
               0: a = 12'h0;
               1: a = 12'h8;
               2: a = 12'hC;
               default: a = 12'h10;
            endcase
            a = 12'hDA0 + 12'(w * 32) + a;
            wr(a, (f == 3) ? rand_attr() : $urandom);
         end else if (op == 2) begin
            wr(12'($urandom), $urandom);
         end else if (op == 3) begin
            a = ($urandom % 2 == 0) ? 12'($urandom) : 12'hC00 + 12'($urandom % 1024);
            rd(a, "R2 R3 R4 R5 random read");
         end else begin
            look(($urandom % 4 == 0) ? $urandom : near_addr(1'b0, $urandom % 4),
                 ($urandom % 4 == 0) ? $urandom : near_addr(1'b1, $urandom % 3),
                 "R8 R9 R10 random lookup");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule